// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Postscaler

This block divides a fast base clock (nominally 100 MHz, made from a 25 MHz reference multiplied by four) down to a slower clock for other devices on the board. A 4-bit setting, written through a simple strobed port that runs on the base clock, selects one of fifteen divide ratios or turns the output off. The output stays close to a 50% duty cycle for every ratio, odd ratios included. For odd ratios, a copy of the output that is retimed on the falling edge stretches each high phase by half a base-clock period.

The setting can be changed while the output is running. The new value is held as pending and takes effect only when the current low phase has run to its end. The new ratio then begins with a full low phase of its own, so no high or low phase is ever shorter than it would be under the old ratio or the new one. Turning the output off lets the current high phase finish. Turning it on from off begins with a full low phase. Only the power-on reset clears the setting and the output; the block has no other reset input. Out of power-on the output runs at base/25, which gives 4 MHz.

Top module: `clk_postscaler`

## Requirements
- R1: After power-on reset, `cfg_q` reads 4'b1010, `busy` is low, and the output runs at base/25 (25 half-periods high, 25 low).
- R2: Codes map to divisors as follows: 4'b0001..4'b1010 give 3, 4, 5, 6, 8, 10, 12, 16, 20, 25, and 4'b1011..4'b1111 give 32, 50, 100, 500, 1000.
- R3: For every divisor N, each steady high phase and each steady low phase of `clk_out` lasts exactly N half-periods of the base clock, for odd and even N.
- R4: Code 4'b0000 holds `clk_out` low.
- R5: With `wr_en` high at a rising base edge, `wr_code` is stored and `cfg_q` shows it after that edge. With `wr_en` low, `wr_code` has no effect on `cfg_q` or `busy`.
- R6: `busy` is high after a write of a code that differs from the one in use, and falls when that code is applied. Writing the code already in use leaves `busy` low.
- R7: A new non-zero code is applied only at the end of a complete low phase, and the output then starts with a low phase of the new divisor. Across the change, no phase is shorter than the smaller of the old and new N.
- R8: A change to code 0 made during a high phase lets that high phase run its full N half-periods. The output then stays low.
- R9: A change from off to a non-zero code starts with the output low, followed by steady phases of the new divisor.
- R10: When several codes are written before one is applied, the last one written is the one applied.
- R11: While `por_n` is low, `clk_out` is low, and `cfg_q` returns to 4'b1010 whatever was written before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base | input | 1 | Base clock to be divided |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the setting |
| wr_code | input | 4 | Code to store when `wr_en` is high |
| cfg_q | output | 4 | Stored setting (last code written) |
| busy | output | 1 | High while a stored code waits to be applied |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench uses the default parameters: a 10-bit phase counter and a power-on code of 4'b1010. A 10-bit counter holds the half-ratio of the largest divisor, 1000, so every code from 4'b0001 to 4'b1111 can be measured, including the odd ratios 3, 5 and 25 where the falling-edge stretch matters. The default power-on code makes base/25 the first ratio seen after reset. The bench also covers switching from a fast ratio to a slow one and back, and writes made in the middle of a high phase and in the middle of a low phase.

// File: rtl/clk_postscaler.sv
module clk_postscaler #(
  parameter int          CW       = 10,
  parameter logic [3:0]  RST_CODE = 4'b1010
) (
  input  logic       clk_base,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [3:0] wr_code,
  output logic [3:0] cfg_q,
  output logic       busy,
  output logic       clk_out
);

  function automatic logic [CW-1:0] div_of(input logic [3:0] c);
    int d;
    case (c)
      4'd1:  d = 3;
      4'd2:  d = 4;
      4'd3:  d = 5;
      4'd4:  d = 6;
      4'd5:  d = 8;
      4'd6:  d = 10;
      4'd7:  d = 12;
      4'd8:  d = 16;
      4'd9:  d = 20;
      4'd10: d = 25;
      4'd11: d = 32;
      4'd12: d = 50;
      4'd13: d = 100;
      4'd14: d = 500;
      4'd15: d = 1000;
      default: d = 0;
    endcase
    return CW'(d);
  endfunction

  logic [3:0]    cfg, act;
  logic          q, qn;
  logic [CW-1:0] ph;

  wire [CW-1:0] n      = div_of(act);
  wire [CW-1:0] hi     = n >> 1;
  wire [CW-1:0] lo     = n - hi;
  wire [CW-1:0] lim    = q ? hi : lo;
  wire          ph_end = (ph == lim - CW'(1));
  wire          pend   = (cfg != act);

  always_ff @(posedge clk_base or negedge por_n) begin
    if (!por_n) begin
      cfg <= RST_CODE;
      act <= RST_CODE;
      q   <= 1'b0;
      ph  <= '0;
    end else begin
      if (wr_en) cfg <= wr_code;
      if (act == 4'd0) begin
        q  <= 1'b0;
        ph <= '0;
        if (pend) act <= cfg;
      end else if (pend && cfg == 4'd0 && (!q || ph_end)) begin
        act <= 4'd0;
        q   <= 1'b0;
        ph  <= '0;
      end else if (!ph_end) begin
        ph <= ph + CW'(1);
      end else begin
        ph <= '0;
        if (!q && pend) act <= cfg;
        else            q   <= ~q;
      end
    end
  end

  always_ff @(negedge clk_base or negedge por_n) begin
    if (!por_n) qn <= 1'b0;
    else        qn <= q & n[0];
  end

  assign clk_out = q | qn;
  assign cfg_q   = cfg;
  assign busy    = pend;

  AST_OFF_LOW: assert property (@(posedge clk_base) disable iff (!por_n)
    (act == 4'd0) |-> !q) else $error("off code drives output high"); // R4

  AST_SWITCH_IN_LOW: assert property (@(posedge clk_base) disable iff (!por_n)
    (act != $past(act) && act != 4'd0) |-> (!$past(q) && !q)) else $error("switch outside low phase"); // R7

  AST_OFF_AFTER_HIGH: assert property (@(posedge clk_base) disable iff (!por_n)
    ($past(act) != 4'd0 && act == 4'd0 && $past(q)) |-> $past(ph_end)) else $error("high phase cut short"); // R8

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_base) disable iff (!por_n)
    !$past(wr_en) |-> $stable(cfg)) else $error("setting moved without write"); // R5

  AST_PH_RANGE: assert property (@(posedge clk_base) disable iff (!por_n)
    (act != 4'd0) |-> (ph < lim)) else $error("phase counter overrun"); // R3

endmodule

// File: tb/clk_postscaler_test.sv
module clk_postscaler_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_code = 4'd0;
  logic [3:0] cfg_q;
  logic       busy, clk_out;

  int total = 0, fails = 0;

  clk_postscaler uut (
    .clk_base(clk), .por_n(por_n), .wr_en(wr_en), .wr_code(wr_code),
    .cfg_q(cfg_q), .busy(busy), .clk_out(clk_out)
  );

  always #2 clk = ~clk;

  localparam logic [3:0] CODES [15] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
                                        4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
  localparam int DIVS [15] = '{3, 4, 5, 6, 8, 10, 12, 16, 20, 25, 32, 50, 100, 500, 1000};

  // run-length monitor: samples 1 ns after every clock edge
  event run_end;
  logic lvl = 1'b0, done_lvl = 1'b0;
  int   run = 0, done_len = 0;
  initial forever begin
    @(clk); #1;
    if (clk_out === lvl) run++;
    else begin
      done_len = run; done_lvl = lvl;
      lvl = clk_out; run = 1;
      ->run_end;
    end
  end

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic wr(input logic [3:0] c);
    @(negedge clk); wr_en = 1'b1; wr_code = c;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  task automatic measure(input int n, input string req);
    int h;
    do @(run_end); while (done_lvl !== 1'b1);
    h = done_len;
    @(run_end);
    chk(h == n, {req, " high"}, h, n);
    chk(done_len == n, {req, " low"}, done_len, n);
  endtask

  task automatic switch_test(input logic [3:0] a, input int na,
                             input logic [3:0] b, input int nb, input int dly);
    int mn;
    mn = (na < nb) ? na : nb;
    wr(a); wait_idle(); measure(na, "R7 before");
    @(run_end);
    repeat (dly) @(negedge clk);
    wr(b);
    for (int i = 0; i < 5; i++) begin
      @(run_end);
      chk(done_len >= mn, "R7 no short phase", done_len, mn);
    end
    wait_idle();
    measure(nb, "R7 after");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b0, "R11 low in reset", clk_out, 0);
    por_n = 1'b1;
    @(negedge clk);
    chk(cfg_q == 4'b1010, "R1 power-on code", cfg_q, 4'b1010);
    chk(busy == 1'b0, "R1 busy idle", busy, 0);
    measure(25, "R1 default /25");

    // R5: code ignored without strobe
    wr_code = 4'd5;
    repeat (4) @(negedge clk);
    chk(cfg_q == 4'b1010, "R5 no write no change", cfg_q, 4'b1010);
    chk(busy == 1'b0, "R5 no write no busy", busy, 0);

    // R6: same code leaves busy low
    wr(4'b1010);
    chk(busy == 1'b0, "R6 same code", busy, 0);

    // R10: overwrite while pending, during a low phase of /25
    do @(run_end); while (done_lvl !== 1'b1);
    wr(4'd1);
    chk(busy == 1'b1, "R6 busy after write", busy, 1);
    chk(cfg_q == 4'd1, "R5 readback", cfg_q, 1);
    wr(4'd2);
    wait_idle();
    chk(busy == 1'b0, "R6 busy clears", busy, 0);
    measure(4, "R10 last write wins");

    // R2/R3: every code
    for (int i = 0; i < 15; i++) begin
      wr(CODES[i]);
      wait_idle();
      measure(DIVS[i], $sformatf("R2 R3 code %0d", CODES[i]));
    end

    switch_test(4'd1, 3, 4'd10, 25, 0);
    switch_test(4'd10, 25, 4'd1, 3, 5);
    switch_test(4'd4, 6, 4'd3, 5, 1);

    // R8: disable during high phase of /8
    wr(4'd5); wait_idle(); measure(8, "R8 setup");
    do @(run_end); while (done_lvl !== 1'b0);
    wr(4'd0);
    @(run_end);
    chk(done_lvl == 1'b1, "R8 high ends first", done_lvl, 1);
    chk(done_len == 8, "R8 full high", done_len, 8);
    begin
      int hi_seen = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); #1; if (clk_out) hi_seen++; end
      chk(hi_seen == 0, "R4 held low", hi_seen, 0);
    end
    chk(cfg_q == 4'd0, "R5 off readback", cfg_q, 0);

    // R9: off to on
    wr(4'd2);
    wait_idle();
    chk(clk_out == 1'b0, "R9 starts low", clk_out, 0);
    measure(4, "R9 steady");

    // R11: power-on reset mid-run
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); #1;
    chk(clk_out == 1'b0, "R11 output low", clk_out, 0);
    chk(cfg_q == 4'b1010, "R11 code restored", cfg_q, 4'b1010);
    por_n = 1'b1;
    measure(25, "R11 back to /25");

    report();
  end
endmodule